// File: doc/BRIEF.md
# Processor State Save, Restore and Vector Fetch Sequencer

This block moves processor state between the core registers and a small hardware stack held in page zero of a byte-wide memory. It serves four kinds of request: a subroutine call that saves a return address, a subroutine return that restores it, an interrupt entry that saves the full register set and then fetches a new program counter from a vector pair near the top of memory, and a return from interrupt that restores everything in reverse. Each memory access takes exactly one clock cycle. The sequencer owns the stack pointer and drives the address, write data and read/write strobes itself.

The surrounding core raises one request for a single cycle while the sequencer is idle. It supplies the return address, the accumulator, the index register and the condition code byte. It then waits for the one-cycle completion pulse, when the restored values and the new program counter can be read from the outputs. A reset-class interrupt fetches its vector without saving anything and puts the stack pointer back at the top of its window. The size of the address map is a parameter given as the high address byte of the top page.

Top module: `stack_vec_seq`

## Requirements
- R1: After the synchronous reset, `sp_out` is 8'hFF, `done` is 0, and both `mem_we` and `mem_re` are 0.
- R2: A call writes the low byte of `pc_in` at the current stack pointer and then the high byte at the next lower stack address, so the pointer goes from 8'hFF to 8'hFD.
- R3: A subroutine return reads the high PC byte first and then the low byte, each at the incremented pointer, and `pc_out` equals {high, low} at completion.
- R4: An interrupt entry with `int_src` 0 or 1 writes PC low, PC high, `x_in`, `a_in` and `ccr_in`, in that order, and the pointer drops by five.
- R5: The pushed condition code byte is `ccr_in` unchanged. After entry, `ccr_out` is `ccr_in` with bit 3 (the interrupt mask) set. A later return from interrupt therefore restores the mask as it was before entry.
- R6: The vector is read high byte first at {TOP_HI, offset} and low byte at {TOP_HI, offset+1}. The offset is 8'hFA for `int_src` 0 (external interrupt), 8'hFC for 1 (software interrupt), and 8'hFE for 2 or 3 (reset). `pc_out` is {high, low}.
- R7: An interrupt entry with `int_src` 2 or 3 makes no write, sets the pointer to 8'hFF, performs only the two vector reads, and sets bit 3 of `ccr_out`.
- R8: A return from interrupt reads the condition code byte, A, X, PC high and PC low, in that order, and presents them on `ccr_out`, `a_out`, `x_out` and `pc_out`.
- R9: The stack pointer stays within 8'hC0..8'hFF. A push at 8'hC0 leaves it at 8'hFF. A pull at 8'hFF reads address 8'hC0 and leaves it there. Thirty-two calls from 8'hFF return the pointer to 8'hFF.
- R10: The first access happens in the cycle after the request is accepted, and the accesses follow on consecutive cycles with exactly one strobe active. `done` is high for exactly one cycle, the cycle after the last access, with no strobe active in that cycle.
- R11: When several requests arrive together, interrupt wins over return from interrupt, which wins over return, which wins over call. Requests raised while a sequence is running are ignored.
- R12: Every stack access uses address {zeros, stack pointer}, which lies in page zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_call | input | 1 | Subroutine call request |
| req_ret | input | 1 | Subroutine return request |
| req_int | input | 1 | Interrupt entry request |
| req_rti | input | 1 | Return from interrupt request |
| int_src | input | 2 | Interrupt source: 0 external, 1 software, 2/3 reset |
| pc_in | input | AW | Return address to save |
| a_in | input | 8 | Accumulator to save |
| x_in | input | 8 | Index register to save |
| ccr_in | input | 8 | Condition code byte to save |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| sp_out | output | 8 | Current stack pointer |
| pc_out | output | AW | New program counter |
| a_out | output | 8 | Restored accumulator |
| x_out | output | 8 | Restored index register |
| ccr_out | output | 8 | Restored or updated condition code byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that requests come only as one-cycle pulses, and that memory returns read data in the same cycle as the address. They also take for granted that the memory answers every address the sequencer can present, so a read strobe outside page zero can only be a vector fetch in the top page. The bench models a memory with combinational reads of the full map. It raises each request for a single cycle while the block is idle and waits for completion before the next. Its only deliberate violation is a burst of requests raised in the middle of a running sequence, which must be ignored.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

    localparam logic [7:0] SP_TOP   = 8'hFF;
    localparam logic [7:0] SP_BOT   = 8'hC0;
    localparam int         CCR_MASK = 3;

    typedef enum logic [1:0] {
        OP_CALL,
        OP_RET,
        OP_INT,
        OP_RTI
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_PCL,
        ST_W_PCH,
        ST_W_X,
        ST_W_A,
        ST_W_CCR,
        ST_V_HI,
        ST_V_LO,
        ST_R_CCR,
        ST_R_A,
        ST_R_X,
        ST_R_PCH,
        ST_R_PCL,
        ST_DONE
    } st_e;

    typedef struct packed {
        op_e         op;
        logic [1:0]  src;
        logic [15:0] pc;
        logic [7:0]  a;
        logic [7:0]  x;
        logic [7:0]  ccr;
    } ctx_t;

    function automatic logic [7:0] vec_offset(input logic [1:0] src);
        case (src)
            2'd0:    return 8'hFA;
            2'd1:    return 8'hFC;
            default: return 8'hFE;
        endcase
    endfunction

    function automatic logic is_push(input st_e s);
        return (s == ST_W_PCL) || (s == ST_W_PCH) || (s == ST_W_X) ||
               (s == ST_W_A)   || (s == ST_W_CCR);
    endfunction

    function automatic logic is_pull(input st_e s);
        return (s == ST_R_CCR) || (s == ST_R_A) || (s == ST_R_X) ||
               (s == ST_R_PCH) || (s == ST_R_PCL);
    endfunction

    function automatic logic [7:0] sp_dec(input logic [7:0] sp);
        return (sp == SP_BOT) ? SP_TOP : sp - 8'd1;
    endfunction

    function automatic logic [7:0] sp_inc(input logic [7:0] sp);
        return (sp == SP_TOP) ? SP_BOT : sp + 8'd1;
    endfunction

endpackage

// File: rtl/stkseq_sp.sv
module stkseq_sp
    import stkseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       init,
    input  logic       push,
    input  logic       pull,
    output logic [7:0] sp,
    output logic [7:0] sp_up
);

    assign sp_up = sp_inc(sp);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            sp <= SP_TOP;
        end else if (push) begin
            sp <= sp_dec(sp);
        end else if (pull) begin
            sp <= sp_up;
        end
    end

endmodule

// File: rtl/stkseq_fsm.sv
module stkseq_fsm
    import stkseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_call,
    input  logic        req_ret,
    input  logic        req_int,
    input  logic        req_rti,
    input  logic [1:0]  int_src,
    input  logic [15:0] pc_in,
    input  logic [7:0]  a_in,
    input  logic [7:0]  x_in,
    input  logic [7:0]  ccr_in,
    output st_e         state,
    output ctx_t        ctx,
    output logic        sp_init
);

    logic accept;
    op_e  new_op;
    st_e  nxt;

    assign accept = (state == ST_IDLE) && (req_call || req_ret || req_int || req_rti);

    always_comb begin
        if (req_int)      new_op = OP_INT;
        else if (req_rti) new_op = OP_RTI;
        else if (req_ret) new_op = OP_RET;
        else              new_op = OP_CALL;
    end

    assign sp_init = accept && (new_op == OP_INT) && int_src[1];

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: begin
                if (accept) begin
                    case (new_op)
                        OP_CALL: nxt = ST_W_PCL;
                        OP_RET:  nxt = ST_R_PCH;
                        OP_RTI:  nxt = ST_R_CCR;
                        default: nxt = int_src[1] ? ST_V_HI : ST_W_PCL;
                    endcase
                end
            end
            ST_W_PCL: nxt = ST_W_PCH;
            ST_W_PCH: nxt = (ctx.op == OP_CALL) ? ST_DONE : ST_W_X;
            ST_W_X:   nxt = ST_W_A;
            ST_W_A:   nxt = ST_W_CCR;
            ST_W_CCR: nxt = ST_V_HI;
            ST_V_HI:  nxt = ST_V_LO;
            ST_V_LO:  nxt = ST_DONE;
            ST_R_CCR: nxt = ST_R_A;
            ST_R_A:   nxt = ST_R_X;
            ST_R_X:   nxt = ST_R_PCH;
            ST_R_PCH: nxt = ST_R_PCL;
            ST_R_PCL: nxt = ST_DONE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ctx   <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                ctx.op  <= new_op;
                ctx.src <= int_src;
                ctx.pc  <= pc_in;
                ctx.a   <= a_in;
                ctx.x   <= x_in;
                ctx.ccr <= ccr_in;
            end
        end
    end

endmodule

// File: rtl/stack_vec_seq.sv
module stack_vec_seq
    import stkseq_pkg::*;
#(
    parameter logic [7:0] TOP_HI = 8'h07,
    localparam int         AW     = $clog2(int'(TOP_HI) + 1) + 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_call,
    input  logic          req_ret,
    input  logic          req_int,
    input  logic          req_rti,
    input  logic [1:0]    int_src,
    input  logic [AW-1:0] pc_in,
    input  logic [7:0]    a_in,
    input  logic [7:0]    x_in,
    input  logic [7:0]    ccr_in,
    input  logic [7:0]    mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    output logic [7:0]    sp_out,
    output logic [AW-1:0] pc_out,
    output logic [7:0]    a_out,
    output logic [7:0]    x_out,
    output logic [7:0]    ccr_out,
    output logic          done
);

    localparam int HW = AW - 8;

    st_e         state;
    ctx_t        ctx;
    logic        sp_init;
    logic        do_push;
    logic        do_pull;
    logic [7:0]  sp;
    logic [7:0]  sp_up;
    logic [7:0]  pc_hi_r;
    logic [7:0]  pc_lo_r;
    logic [15:0] pc_full;
    logic [7:0]  vec_lo;

    stkseq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_call (req_call),
        .req_ret  (req_ret),
        .req_int  (req_int),
        .req_rti  (req_rti),
        .int_src  (int_src),
        .pc_in    ({{(16 - AW){1'b0}}, pc_in}),
        .a_in     (a_in),
        .x_in     (x_in),
        .ccr_in   (ccr_in),
        .state    (state),
        .ctx      (ctx),
        .sp_init  (sp_init)
    );

    assign do_push = is_push(state);
    assign do_pull = is_pull(state);

    stkseq_sp u_sp (
        .clk   (clk),
        .rst   (rst),
        .init  (sp_init),
        .push  (do_push),
        .pull  (do_pull),
        .sp    (sp),
        .sp_up (sp_up)
    );

    assign vec_lo = vec_offset(ctx.src);

    always_comb begin
        mem_we    = do_push;
        mem_re    = do_pull || (state == ST_V_HI) || (state == ST_V_LO);
        mem_wdata = 8'h00;
        mem_addr  = '0;
        if (do_push) begin
            mem_addr = {{HW{1'b0}}, sp};
        end else if (do_pull) begin
            mem_addr = {{HW{1'b0}}, sp_up};
        end else if (state == ST_V_HI) begin
            mem_addr = {TOP_HI[HW-1:0], vec_lo};
        end else if (state == ST_V_LO) begin
            mem_addr = {TOP_HI[HW-1:0], vec_lo | 8'h01};
        end
        case (state)
            ST_W_PCL: mem_wdata = ctx.pc[7:0];
            ST_W_PCH: mem_wdata = ctx.pc[15:8];
            ST_W_X:   mem_wdata = ctx.x;
            ST_W_A:   mem_wdata = ctx.a;
            ST_W_CCR: mem_wdata = ctx.ccr;
            default:  mem_wdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_hi_r <= 8'h00;
            pc_lo_r <= 8'h00;
            a_out   <= 8'h00;
            x_out   <= 8'h00;
            ccr_out <= 8'h00;
        end else begin
            case (state)
                ST_V_HI: begin
                    pc_hi_r <= mem_rdata;
                    ccr_out <= ctx.ccr | (8'h01 << CCR_MASK);
                end
                ST_V_LO:  pc_lo_r <= mem_rdata;
                ST_R_PCH: pc_hi_r <= mem_rdata;
                ST_R_PCL: pc_lo_r <= mem_rdata;
                ST_R_CCR: ccr_out <= mem_rdata;
                ST_R_A:   a_out   <= mem_rdata;
                ST_R_X:   x_out   <= mem_rdata;
                default: ;
            endcase
        end
    end

    assign pc_full = {pc_hi_r, pc_lo_r};
    assign pc_out  = pc_full[AW-1:0];
    assign sp_out  = sp;
    assign done    = (state == ST_DONE);

endmodule

// File: rtl/stkseq_chk.sv
module stkseq_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    sp_out,
    input logic          done
);

    // R12
    stack_page_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[AW-1:6] == {{(AW-8){1'b0}}, 2'b11}));

    // R9
    sp_range_chk: assert property (@(posedge clk) disable iff (rst)
        sp_out[7:6] == 2'b11);

    // R9
    push_step_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp_out == (($past(sp_out) == 8'hC0) ? 8'hFF : $past(sp_out) - 8'd1)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R10
    quiet_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_we && !mem_re));

    // R6
    vector_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_re && (mem_addr[AW-1:8] != '0)) |->
            ((mem_addr[AW-1:8] == {(AW-8){1'b1}}) && (mem_addr[7:0] >= 8'hFA)));

    // R12
    pull_page_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_re && (mem_addr[AW-1:8] == '0)) |-> (mem_addr[7:6] == 2'b11));

endmodule

bind stack_vec_seq stkseq_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .mem_addr (mem_addr),
    .sp_out   (sp_out),
    .done     (done)
);

// File: tb/tb_stack_vec_seq.sv
`timescale 1ns/1ps
module tb_stack_vec_seq;

    localparam logic [7:0] TOP_HI = 8'h07;
    localparam int AW    = 11;
    localparam int MSIZE = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_call, req_ret, req_int, req_rti;
    logic [1:0]    int_src;
    logic [AW-1:0] pc_in;
    logic [7:0]    a_in, x_in, ccr_in;
    logic [7:0]    mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_we, mem_re;
    logic [7:0]    sp_out;
    logic [AW-1:0] pc_out;
    logic [7:0]    a_out, x_out, ccr_out;
    logic          done;

    always #10 clk = ~clk;

    stack_vec_seq #(.TOP_HI(TOP_HI)) dut (
        .clk(clk), .rst(rst),
        .req_call(req_call), .req_ret(req_ret), .req_int(req_int), .req_rti(req_rti),
        .int_src(int_src), .pc_in(pc_in), .a_in(a_in), .x_in(x_in), .ccr_in(ccr_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .sp_out(sp_out), .pc_out(pc_out),
        .a_out(a_out), .x_out(x_out), .ccr_out(ccr_out), .done(done)
    );

    logic [7:0] mem [MSIZE];
    logic [7:0] rmem [MSIZE];
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;
    int ref_sp;

    int q_we[$];
    int q_addr[$];
    int q_wd[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void m_push(input int d);
        q_we.push_back(1); q_addr.push_back(ref_sp); q_wd.push_back(d);
        rmem[ref_sp] = d[7:0];
        ref_sp = (ref_sp == 'hC0) ? 'hFF : ref_sp - 1;
    endfunction

    function automatic int m_pull();
        ref_sp = (ref_sp == 'hFF) ? 'hC0 : ref_sp + 1;
        q_we.push_back(0); q_addr.push_back(ref_sp); q_wd.push_back(0);
        return int'(rmem[ref_sp]);
    endfunction

    function automatic int m_read(input int addr);
        q_we.push_back(0); q_addr.push_back(addr); q_wd.push_back(0);
        return int'(rmem[addr]);
    endfunction

    task automatic run_op(input bit rcall, input bit rret, input bit rint, input bit rrti,
                          input logic [1:0] src, input int pc, input int a, input int x,
                          input int ccr, input bit disturb, input string tag);
        int kind; // 0 call, 1 ret, 2 int, 3 rti
        int e_pc, e_a, e_x, e_ccr, hi, lo, n;
        e_pc = 0; e_a = 0; e_x = 0; e_ccr = 0;
        q_we.delete(); q_addr.delete(); q_wd.delete();
        if (rint) kind = 2; else if (rrti) kind = 3; else if (rret) kind = 1; else kind = 0;
        case (kind)
            0: begin m_push(pc & 'hFF); m_push((pc >> 8) & 'hFF); end
            1: begin hi = m_pull(); lo = m_pull(); e_pc = (hi << 8) | lo; end
            2: begin
                if (src[1]) ref_sp = 'hFF;
                else begin
                    m_push(pc & 'hFF); m_push((pc >> 8) & 'hFF);
                    m_push(x); m_push(a); m_push(ccr);
                end
                lo = (src == 0) ? 'hFA : (src == 1) ? 'hFC : 'hFE;
                hi = m_read((int'(TOP_HI) << 8) | lo);
                lo = m_read((int'(TOP_HI) << 8) | lo | 1);
                e_pc = (hi << 8) | lo;
                e_ccr = ccr | 8;
            end
            default: begin
                e_ccr = m_pull(); e_a = m_pull(); e_x = m_pull();
                hi = m_pull(); lo = m_pull(); e_pc = (hi << 8) | lo;
            end
        endcase
        e_pc = e_pc & (MSIZE - 1);
        n = q_we.size();
        @(negedge clk);
        req_call = rcall; req_ret = rret; req_int = rint; req_rti = rrti;
        int_src = src; pc_in = pc[AW-1:0]; a_in = a[7:0]; x_in = x[7:0]; ccr_in = ccr[7:0];
        @(negedge clk);
        req_call = 0; req_ret = 0; req_int = 0; req_rti = 0;
        for (int i = 0; i < n; i++) begin
            // R10 R12 one access per cycle at the modelled address
            chk(mem_we == q_we[i][0] && mem_re == !q_we[i][0] && !done,
                tag, $sformatf("strobe we/re/done at access %0d", i),
                {mem_we, mem_re, done}, {q_we[i][0], !q_we[i][0], 1'b0});
            chk(int'(mem_addr) == q_addr[i], tag, $sformatf("address at access %0d", i),
                int'(mem_addr), q_addr[i]);
            if (q_we[i] == 1)
                chk(int'(mem_wdata) == q_wd[i], tag, $sformatf("write data at access %0d", i),
                    int'(mem_wdata), q_wd[i]);
            if (disturb && i == 0) begin
                // R11 requests while busy
                req_call = 1; req_ret = 1; req_int = 1; req_rti = 1; int_src = 2'd2;
            end
            if (disturb && i == 1) begin
                req_call = 0; req_ret = 0; req_int = 0; req_rti = 0;
            end
            @(negedge clk);
        end
        // R10 completion cycle
        chk(done == 1'b1 && !mem_we && !mem_re, tag, "done with no strobe",
            {done, mem_we, mem_re}, 3'b100);
        chk(int'(sp_out) == ref_sp, tag, "stack pointer at done", int'(sp_out), ref_sp);
        if (kind != 0)
            chk(int'(pc_out) == e_pc, tag, "pc_out", int'(pc_out), e_pc);
        if (kind >= 2)
            chk(int'(ccr_out) == e_ccr, tag, "ccr_out", int'(ccr_out), e_ccr);
        if (kind == 3) begin
            chk(int'(a_out) == e_a, tag, "a_out", int'(a_out), e_a);
            chk(int'(x_out) == e_x, tag, "x_out", int'(x_out), e_x);
        end
        @(negedge clk);
        chk(!done && !mem_we && !mem_re, tag, "idle after done (R10 R11)",
            {done, mem_we, mem_re}, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < MSIZE; i++) begin
            mem[i] = 8'((i * 37 + 11) & 'hFF);
        end
        mem['h7FA] = 8'h03; mem['h7FB] = 8'h4C;
        mem['h7FC] = 8'h05; mem['h7FD] = 8'hB1;
        mem['h7FE] = 8'h01; mem['h7FF] = 8'h20;
        for (int i = 0; i < MSIZE; i++) rmem[i] = mem[i];
        ref_sp = 'hFF;
        rst = 1; req_call = 0; req_ret = 0; req_int = 0; req_rti = 0;
        int_src = 0; pc_in = '0; a_in = 0; x_in = 0; ccr_in = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(sp_out == 8'hFF, "R1", "sp after reset", int'(sp_out), 'hFF);
        chk(!done && !mem_we && !mem_re, "R1", "strobes after reset",
            {done, mem_we, mem_re}, 0);

        // R7 reset-class vector, no stacking
        run_op(0, 0, 1, 0, 2'd2, 'h3AA, 'h11, 'h22, 'hE0, 0, "R7");
        // R2 call pushes low then high, FF -> FD
        run_op(1, 0, 0, 0, 2'd0, 'h1A5, 0, 0, 0, 0, "R2");
        // R3 return pulls high then low
        run_op(0, 1, 0, 0, 2'd0, 0, 0, 0, 0, 0, "R3");
        // R4 R5 R6 external interrupt entry with mask clear
        run_op(0, 0, 1, 0, 2'd0, 'h2C3, 'h5A, 'h6B, 'hE1, 0, "R4 R5 R6");
        // R6 software interrupt nested, mask already set
        run_op(0, 0, 1, 0, 2'd1, 'h077, 'hA5, 'h96, 'hEA, 0, "R6");
        // R8 R5 returns restore in reverse order
        run_op(0, 0, 0, 1, 2'd0, 0, 0, 0, 0, 0, "R8");
        run_op(0, 0, 0, 1, 2'd0, 0, 0, 0, 0, 0, "R8 R5");
        // R11 priority among simultaneous requests
        run_op(1, 1, 1, 1, 2'd0, 'h155, 'h01, 'h02, 'hE4, 0, "R11");
        run_op(1, 1, 0, 1, 2'd0, 'h0AB, 0, 0, 0, 0, "R11");
        run_op(1, 1, 0, 0, 2'd0, 'h0CD, 0, 0, 0, 0, "R11");
        // R11 requests during a running sequence are ignored
        run_op(1, 0, 0, 0, 2'd0, 'h321, 0, 0, 0, 1, "R11");
        // R6 reset with source code 3
        run_op(0, 0, 1, 0, 2'd3, 'h000, 0, 0, 'hE0, 0, "R6 R7");
        // R9 thirty-two calls wrap the 64-byte window
        for (int k = 0; k < 32; k++) begin
            run_op(1, 0, 0, 0, 2'd0, 'h100 + k * 3, 0, 0, 0, 0, "R9");
        end
        chk(sp_out == 8'hFF, "R9", "sp after 32 calls", int'(sp_out), 'hFF);
        run_op(1, 0, 0, 0, 2'd0, 'h7E1, 0, 0, 0, 0, "R9");
        for (int k = 0; k < 34; k++) begin
            run_op(0, 1, 0, 0, 2'd0, 0, 0, 0, 0, 0, "R9");
        end
        // R9 interrupt entry across the wrap point
        run_op(0, 0, 1, 0, 2'd0, 'h456, 'h33, 'h44, 'hE2, 0, "R9 R4");
        run_op(0, 0, 0, 1, 2'd0, 0, 0, 0, 0, 0, "R9 R8");
        finish_run();
    end

endmodule